// File: doc/BRIEF.md
# Bit-Testable Flag Register

This block is a 16-bit register that a processor writes and reads over its data bus using two separate strobes: a write enable that loads the bus value on a clock edge, and a read enable that places the current contents on the read port. It also answers single-bit queries. A 4-bit select input names one bit, and a single output reports at once whether that bit is set. The output is formed by an AND-OR network over the decoded select lines.

The same design serves as a status (flag) register and as a plain test register. A mode strap chooses between the two. In flag mode, a vector of external status lines can set bits directly. A raised line shows in the contents and in the bit-test result as soon as it is raised, without waiting for a clock edge or a write. The set is then latched on the next edge, so the flag stays set after the line falls. In test mode the external lines are gated off and have no effect. The read port follows a single-driver bus model: it outputs all zeros while the read enable is low.

Top module: `flagreg_top`

## Requirements
- R1: A synchronous active-low reset clears all 16 stored bits. After reset, with no external line raised, a read returns 0x0000.
- R2: When the write enable is high at a rising clock edge, the stored value becomes the write data. A read in the following cycle returns that data, provided no external set is active.
- R3: While the read enable is low, the read port is 0x0000. While it is high, the read port shows the current contents: the stored bits ORed with any active external sets.
- R4: The bit-test output equals bit N of the current contents, where N is the unsigned value of the 4-bit select input (0 names the least significant bit). It responds combinationally in the same cycle.
- R5: In flag mode (mode strap high), raising external line N makes bit N read as 1 and makes the bit test report it, with no clock edge needed. Once a rising edge has passed while the line was high, the bit stays 1 after the line falls.
- R6: In test mode (mode strap low), the external lines have no effect. Neither the read port nor the bit test changes, and no bit is latched by a clock edge.
- R7: If a write and an external set affect the same bit in the same cycle in flag mode, that bit ends at 1. The other bits take the written data.
- R8: With the write enable low, the write data has no effect on the stored contents.
- R9: An external set only ever sets bits. It never clears a stored bit or changes any bit other than its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; storage updates on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe; loads wr_data on the edge |
| wr_data | input | 16 | Write data from the bus |
| rd_en | input | 1 | Read strobe; enables rd_data |
| rd_data | output | 16 | Read data; zero while rd_en is low |
| bit_sel | input | 4 | Index of the bit to test |
| bit_hit | output | 1 | High when the selected bit is set |
| flag_mode | input | 1 | Mode strap: 1 = flag register, 0 = test register |
| ext_set | input | 16 | External set lines, one per bit, active high |

## Verification
On every cycle, the assertions check the read gating and the agreement of the AND-OR bit test with a direct index into the contents. Across clock edges they check that a write lands the data, that any external set active in flag mode is latched (including when it collides with a write), and that nothing changes in test mode without a write. Two properties need a stimulus sequence and are shown only by the bench's scenarios: that an external set is visible before any clock edge, and that the reset state reads as zero. The bench also sweeps every select value over many stored patterns.

// File: rtl/flagreg_pkg.sv
package flagreg_pkg;

  localparam int unsigned FR_DEFAULT_WIDTH = 16;

  typedef enum logic {
    MODE_TEST = 1'b0,
    MODE_FLAG = 1'b1
  } fr_mode_e;

endpackage

// File: rtl/flagreg_store.sv
module flagreg_store #(
  parameter int unsigned WIDTH = flagreg_pkg::FR_DEFAULT_WIDTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             flag_mode,
  input  logic [WIDTH-1:0] ext_set,
  output logic [WIDTH-1:0] ext_gated,
  output logic [WIDTH-1:0] view
);

  logic [WIDTH-1:0] stored_q;
  logic [WIDTH-1:0] stored_d;

  // external lines pass only in flag mode
  function automatic logic [WIDTH-1:0] gate_ext(input logic mode,
                                                input logic [WIDTH-1:0] ext);
    return (mode == 1'(flagreg_pkg::MODE_FLAG)) ? ext : '0;
  endfunction

  // bus write first, then external sets ORed on top so they win
  function automatic logic [WIDTH-1:0] next_value(input logic we,
                                                  input logic [WIDTH-1:0] wd,
                                                  input logic [WIDTH-1:0] cur,
                                                  input logic [WIDTH-1:0] setv);
    return (we ? wd : cur) | setv;
  endfunction

  assign ext_gated = gate_ext(flag_mode, ext_set);
  assign stored_d  = next_value(wr_en, wr_data, stored_q, ext_gated);

  always_ff @(posedge clk) begin
    if (!rst_n) stored_q <= '0;
    else        stored_q <= stored_d;
  end

  // live contents: a raised flag is visible before any edge
  assign view = stored_q | ext_gated;

endmodule

// File: rtl/flagreg_tester.sv
module flagreg_tester #(
  parameter int unsigned WIDTH = flagreg_pkg::FR_DEFAULT_WIDTH,
  localparam int unsigned SEL_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] view,
  input  logic [SEL_W-1:0] bit_sel,
  output logic             bit_hit
);

  function automatic logic [WIDTH-1:0] sel_decode(input logic [SEL_W-1:0] s);
    logic [WIDTH-1:0] d;
    for (int i = 0; i < WIDTH; i++) d[i] = (s == SEL_W'(i));
    return d;
  endfunction

  logic [WIDTH-1:0] sel_lines;
  logic [WIDTH-1:0] and_terms;

  assign sel_lines = sel_decode(bit_sel);

  for (genvar g = 0; g < WIDTH; g++) begin : g_and
    assign and_terms[g] = view[g] & sel_lines[g];
  end

  assign bit_hit = |and_terms;

endmodule

// File: rtl/flagreg_bus.sv
module flagreg_bus #(
  parameter int unsigned WIDTH = flagreg_pkg::FR_DEFAULT_WIDTH
) (
  input  logic             rd_en,
  input  logic [WIDTH-1:0] view,
  output logic [WIDTH-1:0] rd_data
);

  for (genvar g = 0; g < WIDTH; g++) begin : g_gate
    assign rd_data[g] = view[g] & rd_en;
  end

endmodule

// File: rtl/flagreg_top.sv
module flagreg_top #(
  parameter int unsigned WIDTH = flagreg_pkg::FR_DEFAULT_WIDTH,
  localparam int unsigned SEL_W = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  input  logic [SEL_W-1:0] bit_sel,
  output logic             bit_hit,
  input  logic             flag_mode,
  input  logic [WIDTH-1:0] ext_set
);

  logic [WIDTH-1:0] view_w;
  logic [WIDTH-1:0] ext_gated_w;

  flagreg_store #(.WIDTH(WIDTH)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .flag_mode (flag_mode),
    .ext_set   (ext_set),
    .ext_gated (ext_gated_w),
    .view      (view_w)
  );

  flagreg_tester #(.WIDTH(WIDTH)) u_tester (
    .view    (view_w),
    .bit_sel (bit_sel),
    .bit_hit (bit_hit)
  );

  flagreg_bus #(.WIDTH(WIDTH)) u_bus (
    .rd_en   (rd_en),
    .view    (view_w),
    .rd_data (rd_data)
  );

endmodule

// File: rtl/flagreg_checker.sv
module flagreg_checker #(
  parameter int unsigned WIDTH = 16,
  localparam int unsigned SEL_W = $clog2(WIDTH)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [WIDTH-1:0] wr_data,
  input logic             rd_en,
  input logic [WIDTH-1:0] rd_data,
  input logic [SEL_W-1:0] bit_sel,
  input logic             bit_hit,
  input logic             flag_mode,
  input logic [WIDTH-1:0] ext_set,
  input logic [WIDTH-1:0] view,
  input logic [WIDTH-1:0] ext_gated
);

  p_rd_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> rd_data == '0);

  p_rd_show_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> rd_data == view);

  p_hit_index_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bit_hit == view[bit_sel]);

  p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !flag_mode |=> flag_mode || view == $past(wr_data));

  p_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    flag_mode |=> (view & $past(ext_set)) == $past(ext_set));

  p_set_beats_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flag_mode && wr_en |=> (view & $past(ext_set)) == $past(ext_set));

  p_test_ignores_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_mode |-> ext_gated == '0);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_mode && !wr_en |=> flag_mode || view == $past(view));

endmodule

bind flagreg_top flagreg_checker #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_data   (wr_data),
  .rd_en     (rd_en),
  .rd_data   (rd_data),
  .bit_sel   (bit_sel),
  .bit_hit   (bit_hit),
  .flag_mode (flag_mode),
  .ext_set   (ext_set),
  .view      (view_w),
  .ext_gated (ext_gated_w)
);

// File: tb/sim_flagreg_top.sv
module sim_flagreg_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [15:0] wr_data;
  logic        rd_en;
  logic [15:0] rd_data;
  logic [3:0]  bit_sel;
  logic        bit_hit;
  logic        flag_mode;
  logic [15:0] ext_set;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flagreg_top u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .bit_sel(bit_sel), .bit_hit(bit_hit),
    .flag_mode(flag_mode), .ext_set(ext_set)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // advance one rising edge; return just after the falling edge
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic write_word(input logic [15:0] v);
    wr_en = 1'b1; wr_data = v;
    tick();
    wr_en = 1'b0; wr_data = ~v;
  endtask

  // read port value and every bit-test result against a model word
  task automatic check_contents(input string req, input logic [15:0] exp);
    rd_en = 1'b1; #1;
    chk(req, rd_data, exp);
    for (int s = 0; s < 16; s++) begin
      bit_sel = 4'(s); #1;
      chk("R4", {15'd0, bit_hit}, {15'd0, exp[s]});
    end
    rd_en = 1'b0; #1;
    chk("R3", rd_data, 16'h0000);
  endtask

  function automatic logic [15:0] mix(input logic [15:0] x);
    logic [15:0] y;
    y = x ^ (x << 7);
    y = y ^ (y >> 9);
    y = y ^ (y << 8);
    return y;
  endfunction

  initial begin
    logic [15:0] pat;
    logic [15:0] model;
    rst_n = 1'b0; wr_en = 1'b0; wr_data = 16'hFFFF; rd_en = 1'b0;
    bit_sel = '0; flag_mode = 1'b0; ext_set = '0;
    @(negedge clk);
    tick(); tick();
    rst_n = 1'b1;
    check_contents("R1", 16'h0000);

    // R2 / R4: walking ones, walking zeros and mixed words
    for (int k = 0; k < 16; k++) begin
      pat = 16'h0001 << k;
      write_word(pat);
      check_contents("R2", pat);
      write_word(~pat);
      check_contents("R2", ~pat);
    end
    pat = 16'hACE1;
    for (int k = 0; k < 12; k++) begin
      pat = mix(pat);
      write_word(pat);
      check_contents("R2", pat);
    end
    model = pat;

    // R8: data bus toggles without a write strobe
    for (int k = 0; k < 4; k++) begin
      wr_data = mix(model ^ 16'(k + 1));
      tick();
      rd_en = 1'b1; #1;
      chk("R8", rd_data, model);
      rd_en = 1'b0;
    end

    // R6: test mode ignores every external line
    write_word(16'h5A00);
    ext_set = 16'hFFFF; #1;
    check_contents("R6", 16'h5A00);
    tick();
    check_contents("R6", 16'h5A00);
    ext_set = 16'h0000;
    tick();
    check_contents("R6", 16'h5A00);

    // R5 / R9: each line in flag mode, visible before the edge, then sticky
    write_word(16'h0000);
    flag_mode = 1'b1;
    model = 16'h0000;
    for (int k = 0; k < 16; k++) begin
      ext_set = 16'h0001 << k; #1;
      bit_sel = 4'(k); rd_en = 1'b1; #1;
      chk("R5", {15'd0, bit_hit}, 16'h0001);
      chk("R9", rd_data, model | ext_set);
      rd_en = 1'b0;
      tick();
      ext_set = 16'h0000;
      model = model | (16'h0001 << k);
      check_contents("R5", model);
    end

    // R9: a set line leaves stored ones and zeros elsewhere alone
    flag_mode = 1'b0;
    write_word(16'h00F0);
    flag_mode = 1'b1;
    ext_set = 16'h0F00;
    tick();
    ext_set = 16'h0000;
    check_contents("R9", 16'h0FF0);

    // R7: write and set on the same cycle
    wr_en = 1'b1; wr_data = 16'h0000; ext_set = 16'h0100;
    tick();
    wr_en = 1'b0; ext_set = 16'h0000;
    check_contents("R7", 16'h0100);
    wr_en = 1'b1; wr_data = 16'h00FF; ext_set = 16'h8001;
    tick();
    wr_en = 1'b0; ext_set = 16'h0000;
    check_contents("R7", 16'h80FF);

    // R1: reset again after activity
    rst_n = 1'b0;
    tick();
    rst_n = 1'b1;
    check_contents("R1", 16'h0000);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule